// File: doc/BRIEF.md
# Triple-Redundant Read/Write Control Machine

This block is a small transfer controller that runs a read/write handshake. It is built three times over so that a single upset register cannot disturb it. Each of the three copies holds its own state register, a captured transfer word, an output word register and a completion flag. A bitwise two-of-three voter combines every copy's registers on every cycle, and only the voted values drive the outputs. All three copies compute their next values from the voted values, not from their own registers. A copy that has been knocked out of line therefore rejoins the other two at the next clock edge.

A write request taken in the idle state captures the input word. A read request taken in the idle state copies the captured word into the output register one cycle later. Either operation ends with a one-cycle completion strobe. For test, an upset-injection input flips one chosen state bit of one chosen copy at a clock edge. A per-copy disagreement flag shows which copy differs from the vote during the cycle after the upset.

Top module: `tmr_rw_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, all three copies go to idle and the captured word, `dout`, `done` and `mismatch` all become zero. A later read with no write in between returns zero.
- R2: In idle, `rd_req` high at an edge starts a read. When `rd_req` and `wr_req` are both high, the read wins and the captured word is left unchanged.
- R3: In idle, `wr_req` high with `rd_req` low starts a write and captures `din` at that edge as the stored word.
- R4: A read or write spends exactly one cycle in its active state and then returns to idle. `done` is high for exactly the one cycle after the active cycle and is low in every other cycle.
- R5: When a read completes, `dout` changes to the stored word in the same cycle that `done` rises. At all other times `dout` holds its value.
- R6: Each visible output (`dout`, `done`) and the fed-back state is the bitwise majority of the three copies' registers.
- R7: With `upset_en` high at an edge and `upset_copy` set to 0, 1 or 2, the state bit indexed by `upset_bit` in that copy is inverted at that edge. `upset_copy` = 3 changes nothing. State codes are idle = 00, read = 01 and write = 10.
- R8: A single-copy upset, whether injected while idle, at a read start or at a write start, leaves `dout`, `done` and the operation sequence exactly as they would be without it.
- R9: `mismatch[c]` is high exactly while copy c's state differs from the voted state. After one upset it is high for one cycle and then clears, with no further action needed.
- R10: Requests that arrive while a read or write is active are ignored. They neither start a new operation nor change the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read request, sampled in idle |
| wr_req | input | 1 | Write request, sampled in idle |
| din | input | DATA_W | Word captured on an accepted write |
| dout | output | DATA_W | Voted output word register |
| done | output | 1 | Voted one-cycle completion strobe |
| upset_en | input | 1 | Test only: inject a state bit flip at this edge |
| upset_copy | input | 2 | Test only: copy to upset (3 = none) |
| upset_bit | input | ST_SEL_W (1) | Test only: index of the state bit to invert |
| mismatch | output | 3 | Per-copy flag: copy state differs from the vote |

## Verification
The main function is driven by a table of operations. The table includes writes followed by reads with words of all zeros, all ones and mixed patterns, back-to-back writes that must leave only the last word, and simultaneous read and write requests that must resolve to a read without loading the word. Directed cases then inject upsets into each copy and each state bit. This is done in idle, at the acceptance edge of a write and at the acceptance edge of a read. Each case separates a correctly masked upset from one that leaks into `done`, `dout` or the next state, and confirms that the flag names the right copy and clears on its own. Further cases cover reset in the middle of an operation and requests that arrive during an active cycle, which show whether the stored word and the state sequence are protected.

// File: rtl/tmr_rw_pkg.sv
package tmr_rw_pkg;
   localparam int ST_W     = 2;
   localparam int ST_SEL_W = (ST_W > 1) ? $clog2(ST_W) : 1;
   localparam int N_COPY   = 3;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE = 2'b00,
      ST_RD   = 2'b01,
      ST_WR   = 2'b10
   } rw_state_e;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
   parameter int W = 1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] y
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tmr_vote: W must be at least 1");
      end
   endgenerate

   always_comb y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_rw_copy.sv
module tmr_rw_copy
   import tmr_rw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] din,
   input  logic [ST_W-1:0]   st_fb,
   input  logic [DATA_W-1:0] word_fb,
   input  logic [DATA_W-1:0] dout_fb,
   input  logic [ST_W-1:0]   flip_mask,
   output logic [ST_W-1:0]   st_q,
   output logic [DATA_W-1:0] word_q,
   output logic [DATA_W-1:0] dout_q,
   output logic              done_q
);
   logic [ST_W-1:0]   st_n;
   logic [DATA_W-1:0] word_n;
   logic [DATA_W-1:0] dout_n;
   logic              done_n;

   always_comb begin
      st_n   = ST_IDLE;
      word_n = word_fb;
      dout_n = dout_fb;
      done_n = 1'b0;
      case (st_fb)
         ST_IDLE: begin
            if (rd_req) begin
               st_n = ST_RD;
            end else if (wr_req) begin
               st_n   = ST_WR;
               word_n = din;
            end
         end
         ST_RD: begin
            dout_n = word_fb;
            done_n = 1'b1;
         end
         ST_WR: begin
            done_n = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         word_q <= '0;
         dout_q <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_n ^ flip_mask;
         word_q <= word_n;
         dout_q <= dout_n;
         done_q <= done_n;
      end
   end
endmodule

// File: rtl/tmr_rw_ctrl.sv
module tmr_rw_ctrl
   import tmr_rw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit VOTE_DATA = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rd_req,
   input  logic                wr_req,
   input  logic [DATA_W-1:0]   din,
   output logic [DATA_W-1:0]   dout,
   output logic                done,
   input  logic                upset_en,
   input  logic [1:0]          upset_copy,
   input  logic [ST_SEL_W-1:0] upset_bit,
   output logic [N_COPY-1:0]   mismatch
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("tmr_rw_ctrl: DATA_W must be at least 1");
      end
      if (N_COPY != 3) begin : g_bad_nc
         $error("tmr_rw_ctrl: voting needs exactly three copies");
      end
   endgenerate

   logic [ST_W-1:0]   st_q   [N_COPY];
   logic [DATA_W-1:0] word_q [N_COPY];
   logic [DATA_W-1:0] dout_q [N_COPY];
   logic              done_q [N_COPY];
   logic [ST_W-1:0]   flip   [N_COPY];
   logic [DATA_W-1:0] word_fb[N_COPY];
   logic [DATA_W-1:0] dout_fb[N_COPY];

   logic [ST_W-1:0]   st_v;
   logic [DATA_W-1:0] word_v;
   logic [DATA_W-1:0] dout_v;
   logic              done_v;

   genvar c;
   generate
      for (c = 0; c < N_COPY; c++) begin : g_copy
         assign flip[c] = (upset_en && (upset_copy == 2'(c)))
                          ? (ST_W'(1) << upset_bit) : '0;

         if (VOTE_DATA) begin : g_fb_voted
            assign word_fb[c] = word_v;
            assign dout_fb[c] = dout_v;
         end else begin : g_fb_own
            assign word_fb[c] = word_q[c];
            assign dout_fb[c] = dout_q[c];
         end

         tmr_rw_copy #(.DATA_W(DATA_W)) copy_i (
            .clk       (clk),
            .rst       (rst),
            .rd_req    (rd_req),
            .wr_req    (wr_req),
            .din       (din),
            .st_fb     (st_v),
            .word_fb   (word_fb[c]),
            .dout_fb   (dout_fb[c]),
            .flip_mask (flip[c]),
            .st_q      (st_q[c]),
            .word_q    (word_q[c]),
            .dout_q    (dout_q[c]),
            .done_q    (done_q[c])
         );

         assign mismatch[c] = (st_q[c] != st_v);
      end
   endgenerate

   tmr_vote #(.W(ST_W)) vote_st_i (
      .a(st_q[0]), .b(st_q[1]), .c(st_q[2]), .y(st_v)
   );
   tmr_vote #(.W(DATA_W)) vote_word_i (
      .a(word_q[0]), .b(word_q[1]), .c(word_q[2]), .y(word_v)
   );
   tmr_vote #(.W(DATA_W)) vote_dout_i (
      .a(dout_q[0]), .b(dout_q[1]), .c(dout_q[2]), .y(dout_v)
   );
   tmr_vote #(.W(1)) vote_done_i (
      .a(done_q[0]), .b(done_q[1]), .c(done_q[2]), .y(done_v)
   );

   assign dout = dout_v;
   assign done = done_v;
endmodule

// File: rtl/tmr_rw_ctrl_chk.sv
module tmr_rw_ctrl_chk
   import tmr_rw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_req,
   input logic              wr_req,
   input logic              upset_en,
   input logic [1:0]        upset_copy,
   input logic [DATA_W-1:0] dout,
   input logic              done,
   input logic [2:0]        mismatch,
   input logic [ST_W-1:0]   st_v,
   input logic [DATA_W-1:0] word_v
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (dout == '0 && !done && mismatch == 3'b000));

   // R2
   read_start_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v == ST_IDLE && rd_req) |=> st_v == ST_RD);

   // R3
   write_start_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v == ST_IDLE && wr_req && !rd_req) |=> st_v == ST_WR);

   // R4
   done_after_op_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v != ST_IDLE) |=> (done && st_v == ST_IDLE));

   // R4
   no_done_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v == ST_IDLE) |=> !done);

   // R5
   read_loads_dout_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v == ST_RD) |=> dout == $past(word_v));

   // R5
   dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v != ST_RD) |=> $stable(dout));

   // R10
   word_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (st_v != ST_IDLE) |=> $stable(word_v));

   // R7
   upset_seen_chk: assert property (@(posedge clk) disable iff (rst)
      (upset_en && upset_copy != 2'd3) |=> mismatch != 3'b000);

   // R9
   mismatch_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (mismatch != 3'b000 && !upset_en) |=> mismatch == 3'b000);

   // R9
   single_copy_flag_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mismatch));
endmodule

bind tmr_rw_ctrl tmr_rw_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .rd_req     (rd_req),
   .wr_req     (wr_req),
   .upset_en   (upset_en),
   .upset_copy (upset_copy),
   .dout       (dout),
   .done       (done),
   .mismatch   (mismatch),
   .st_v       (st_v),
   .word_v     (word_v)
);

// File: tb/tmr_rw_ctrl_tb_top.sv
module tmr_rw_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 32;
   localparam int N_VEC      = 11;

   // {op, data, expected dout}; op 0 = write, 1 = read, 2 = both requests
   localparam logic [65:0] VEC [N_VEC] = '{
      {2'd0, 32'hDEADBEEF, 32'h00000000},
      {2'd1, 32'h00000000, 32'hDEADBEEF},
      {2'd0, 32'h12345678, 32'hDEADBEEF},
      {2'd0, 32'hA5A5A5A5, 32'hDEADBEEF},
      {2'd1, 32'h00000000, 32'hA5A5A5A5},
      {2'd2, 32'h0F0F0F0F, 32'hA5A5A5A5},
      {2'd1, 32'h00000000, 32'hA5A5A5A5},
      {2'd0, 32'hFFFFFFFF, 32'hA5A5A5A5},
      {2'd1, 32'h00000000, 32'hFFFFFFFF},
      {2'd0, 32'h00000000, 32'hFFFFFFFF},
      {2'd1, 32'h00000000, 32'h00000000}
   };

   logic          clk = 1'b0;
   logic          rst;
   logic          rd_req;
   logic          wr_req;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          done;
   logic          upset_en;
   logic [1:0]    upset_copy;
   logic [0:0]    upset_bit;
   logic [2:0]    mismatch;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_rw_ctrl #(.DATA_W(DW)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .rd_req     (rd_req),
      .wr_req     (wr_req),
      .din        (din),
      .dout       (dout),
      .done       (done),
      .upset_en   (upset_en),
      .upset_copy (upset_copy),
      .upset_bit  (upset_bit),
      .mismatch   (mismatch)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_op(input logic [1:0] op, input logic [31:0] data,
                         input logic [31:0] exp, input string req);
      rd_req = (op != 2'd0);
      wr_req = (op != 2'd1);
      din    = data;
      step;
      rd_req = 1'b0;
      wr_req = 1'b0;
      din    = 32'h5555AAAA;
      step;
      chk({req, " R4 done pulse"}, 32'(done), 32'd1);
      chk({req, " R5 dout"}, dout, exp);
      step;
      chk({req, " R4 done single cycle"}, 32'(done), 32'd0);
   endtask

   task automatic inject_idle(input logic [1:0] cp, input logic bt,
                              input logic [2:0] exp_mm, input logic [31:0] exp_dout);
      upset_en   = 1'b1;
      upset_copy = cp;
      upset_bit  = bt;
      step;
      upset_en = 1'b0;
      chk("R7 R9 mismatch after upset", 32'(mismatch), 32'(exp_mm));
      chk("R8 done masked", 32'(done), 32'd0);
      chk("R6 dout voted", dout, exp_dout);
      step;
      chk("R9 mismatch cleared", 32'(mismatch), 32'd0);
      chk("R8 no spurious done", 32'(done), 32'd0);
   endtask

   initial begin
      rst = 1'b1; rd_req = 1'b0; wr_req = 1'b0; din = '0;
      upset_en = 1'b0; upset_copy = 2'd0; upset_bit = 1'b0;
      @(negedge clk);
      step;
      step;
      chk("R1 dout after reset", dout, 32'd0);
      chk("R1 done after reset", 32'(done), 32'd0);
      chk("R1 mismatch after reset", 32'(mismatch), 32'd0);
      rst = 1'b0;
      step;

      for (int i = 0; i < N_VEC; i++) begin
         logic [1:0]  op;
         logic [31:0] data;
         logic [31:0] exp;
         op   = VEC[i][65:64];
         data = VEC[i][63:32];
         exp  = VEC[i][31:0];
         run_op(op, data, exp, (op == 2'd0) ? "R3" : ((op == 2'd1) ? "R5" : "R2"));
      end

      // R10: write request during an active read is ignored
      run_op(2'd0, 32'h11112222, 32'h00000000, "R3");
      rd_req = 1'b1;
      step;
      rd_req = 1'b0;
      wr_req = 1'b1;
      din    = 32'h99999999;
      step;
      wr_req = 1'b0;
      chk("R10 read completes", 32'(done), 32'd1);
      chk("R10 dout", dout, 32'h11112222);
      step;
      chk("R10 no extra op", 32'(done), 32'd0);
      step;
      chk("R10 still idle", 32'(done), 32'd0);
      run_op(2'd1, 32'h0, 32'h11112222, "R10");

      // R7 / R9 / R8: upsets in idle
      inject_idle(2'd1, 1'b0, 3'b010, 32'h11112222);
      inject_idle(2'd2, 1'b1, 3'b100, 32'h11112222);
      inject_idle(2'd0, 1'b1, 3'b001, 32'h11112222);
      inject_idle(2'd3, 1'b0, 3'b000, 32'h11112222);

      // R8: upset at write acceptance (copy 0 flipped from write to idle)
      wr_req = 1'b1; din = 32'hCAFEF00D;
      upset_en = 1'b1; upset_copy = 2'd0; upset_bit = 1'b1;
      step;
      wr_req = 1'b0; upset_en = 1'b0;
      chk("R9 mismatch at write", 32'(mismatch), 32'b001);
      step;
      chk("R8 write done kept", 32'(done), 32'd1);
      chk("R9 realigned", 32'(mismatch), 32'd0);
      step;
      run_op(2'd1, 32'h0, 32'hCAFEF00D, "R8");

      // R8: upset at read acceptance (copy 2 flipped from read to idle)
      rd_req = 1'b1;
      upset_en = 1'b1; upset_copy = 2'd2; upset_bit = 1'b0;
      step;
      rd_req = 1'b0; upset_en = 1'b0;
      chk("R9 mismatch at read", 32'(mismatch), 32'b100);
      step;
      chk("R8 read done kept", 32'(done), 32'd1);
      chk("R8 read dout kept", dout, 32'hCAFEF00D);
      step;
      chk("R8 done single", 32'(done), 32'd0);

      // R1: reset in the middle of a write
      wr_req = 1'b1; din = 32'h76543210;
      step;
      wr_req = 1'b0;
      rst = 1'b1;
      step;
      chk("R1 mid-op done", 32'(done), 32'd0);
      chk("R1 mid-op dout", dout, 32'd0);
      rst = 1'b0;
      step;
      chk("R1 stays idle", 32'(done), 32'd0);
      run_op(2'd1, 32'h0, 32'h00000000, "R1");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired before the end of the run");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule